// File: doc/BRIEF.md
# Partitioned Packed-Lane Adder

This block is a 64-bit integer adder whose carry chain can be split so that one physical adder works either as a single full-width add or as several narrow adds running side by side. A two-bit mode input chooses the element width for each operation: 8, 16, 32 or 64 bits. Each packed element adds on its own, and a carry out of one element never reaches the element above it.

Each element reports its carry-out on its own bit of a per-lane carry vector, so software can still detect unsigned overflow lane by lane. The adder is built from 8-bit slices. A small control decoder turns the mode into gate strobes that let a carry pass between slices, and into markers for where each lane ends. An optional output register, present by default, adds one cycle of latency.

Top module: `simd_packed_adder`

## Requirements
- R1: With mode 2'b00 the word holds eight 8-bit lanes, and each lane's sum is (a+b) mod 2^8.
- R2: With mode 2'b01 the word holds four 16-bit lanes, and each lane's sum is (a+b) mod 2^16.
- R3: With mode 2'b10 the word holds two 32-bit lanes, and each lane's sum is (a+b) mod 2^32.
- R4: With mode 2'b11 the word is one 64-bit lane, and its sum is (a+b) mod 2^64.
- R5: No carry crosses a lane boundary. An all-ones lane plus one gives zero in that lane and leaves the next lane unchanged.
- R6: Lane k occupies bits [k*W +: W], with lane 0 at the least significant end. Its carry-out appears on carry bit k.
- R7: Carry bits at or above the active lane count (8, 4, 2 or 1) are zero.
- R8: With the output register enabled, outputs show the inputs of the previous rising edge, and an active-low reset clears both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | 64 | First packed operand |
| opB | input | 64 | Second packed operand |
| laneMode | input | 2 | Lane width: 00=8, 01=16, 10=32, 11=64 bits |
| sumOut | output | 64 | Packed lane sums |
| carryOut | output | 8 | Per-lane carry-out, bit k for lane k |

## Verification
In a single cycle, a lane can produce a carry-out while the lane above it must see none of that carry. The bench provokes this by adding all-ones elements to one, and by driving the same operands under each mode in turn. It judges both outputs against an arithmetic model that works lane by lane. Mode changes between back-to-back cycles are also checked, so that a stale gate setting cannot leak into the next result.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
  localparam int DATA_W     = 64;
  localparam int SLICE_W    = 8;
  localparam int NUM_SLICES = DATA_W / SLICE_W;
  localparam int IDX_W      = $clog2(NUM_SLICES);

  typedef enum logic [1:0] {
    LANE8  = 2'b00,
    LANE16 = 2'b01,
    LANE32 = 2'b10,
    LANE64 = 2'b11
  } laneMode_e;

  typedef struct packed {
    logic [NUM_SLICES-1:0] carryPass;
    logic [NUM_SLICES-1:0] laneEnd;
    logic [1:0]            spanLog;
  } laneCtrl_t;
endpackage

// File: rtl/simd_lane_ctrl.sv
module simd_lane_ctrl
  import simd_add_pkg::*;
(
  input  laneMode_e mode,
  output laneCtrl_t ctrl
);
  logic [IDX_W-1:0] spanMask;

  always_comb begin
    spanMask = IDX_W'((1 << mode) - 1);
    ctrl.spanLog = mode;
    for (int i = 0; i < NUM_SLICES; i++) begin
      ctrl.carryPass[i] = (IDX_W'(i) & spanMask) != '0;
      ctrl.laneEnd[i]   = (IDX_W'(i) & spanMask) == spanMask;
    end
  end
endmodule

// File: rtl/simd_slice_datapath.sv
module simd_slice_datapath
  import simd_add_pkg::*;
(
  input  logic [DATA_W-1:0]     a,
  input  logic [DATA_W-1:0]     b,
  input  laneCtrl_t             ctrl,
  output logic [DATA_W-1:0]     sum,
  output logic [NUM_SLICES-1:0] carryVec
);
  logic [NUM_SLICES-1:0] sliceCin;
  logic [NUM_SLICES-1:0] sliceCout;

  genvar g;
  generate
    for (g = 0; g < NUM_SLICES; g++) begin : gSlice
      if (g == 0) begin : gFirst
        assign sliceCin[g] = 1'b0;
      end else begin : gRest
        assign sliceCin[g] = ctrl.carryPass[g] & sliceCout[g-1];
      end
      assign {sliceCout[g], sum[g*SLICE_W +: SLICE_W]} =
        {1'b0, a[g*SLICE_W +: SLICE_W]} + {1'b0, b[g*SLICE_W +: SLICE_W]}
        + {{SLICE_W{1'b0}}, sliceCin[g]};
    end
  endgenerate

  always_comb begin
    logic [IDX_W-1:0] laneIdx;
    carryVec = '0;
    for (int i = 0; i < NUM_SLICES; i++) begin
      laneIdx = IDX_W'(i) >> ctrl.spanLog;
      if (ctrl.laneEnd[i]) carryVec[laneIdx] = sliceCout[i];
    end
  end
endmodule

// File: rtl/simd_packed_adder.sv
module simd_packed_adder
  import simd_add_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [DATA_W-1:0]     opA,
  input  logic [DATA_W-1:0]     opB,
  input  logic [1:0]            laneMode,
  output logic [DATA_W-1:0]     sumOut,
  output logic [NUM_SLICES-1:0] carryOut
);
  laneCtrl_t             laneCtrl;
  logic [DATA_W-1:0]     rawSum;
  logic [NUM_SLICES-1:0] rawCarry;

  simd_lane_ctrl u_ctrl (
    .mode (laneMode_e'(laneMode)),
    .ctrl (laneCtrl)
  );

  simd_slice_datapath u_dp (
    .a        (opA),
    .b        (opB),
    .ctrl     (laneCtrl),
    .sum      (rawSum),
    .carryVec (rawCarry)
  );

  generate
    if (REG_OUT) begin : gReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sumOut   <= '0;
          carryOut <= '0;
        end else begin
          sumOut   <= rawSum;
          carryOut <= rawCarry;
        end
      end

      AST_FULL_ADD: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && $past(laneMode) == 2'b11) |->
        ({carryOut[0], sumOut} == {1'b0, $past(opA)} + {1'b0, $past(opB)})); // R4

      AST_BYTE_ISOLATION: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && $past(laneMode) == 2'b00) |->
        (sumOut[15:8] == 8'($past(opA[15:8]) + $past(opB[15:8])))); // R5

      AST_UNUSED_CARRY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && $past(laneMode) == 2'b10) |-> (carryOut[7:2] == '0)); // R7

      AST_CARRY_COUNT: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && $past(laneMode) == 2'b01) |->
        ($countones(carryOut) <= 4 && carryOut[7:4] == '0)); // R7

      AST_RESET_CLEAR: assert property (@(posedge clk)
        (!rstN) |=> (!$past(rstN) && !rstN) |-> (sumOut == '0 && carryOut == '0)); // R8
    end else begin : gComb
      assign sumOut   = rawSum;
      assign carryOut = rawCarry;
    end
  endgenerate
endmodule

// File: tb/simd_packed_adder_tb.sv
module simd_packed_adder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [1:0]  laneMode = 2'b00;
  logic [63:0] sumOut;
  logic [7:0]  carryOut;
  int testCount = 0;
  int failCount = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;

  simd_packed_adder u_dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB),
    .laneMode(laneMode), .sumOut(sumOut), .carryOut(carryOut)
  );

  function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                input logic [1:0] m, output logic [63:0] s,
                                output logic [7:0] c);
    int w = 8 << m;
    int n = 64 / w;
    s = '0; c = '0;
    for (int k = 0; k < n; k++) begin
      logic [64:0] ea = '0, eb = '0, t;
      for (int j = 0; j < w; j++) begin
        ea[j] = a[k*w+j];
        eb[j] = b[k*w+j];
      end
      t = ea + eb;
      for (int j = 0; j < w; j++) s[k*w+j] = t[j];
      c[k] = t[w];
    end
  endfunction

  function automatic logic [63:0] pattern(input int idx, input int w);
    logic [63:0] ones = (w == 64) ? '1 : ((64'd1 << w) - 1);
    case (idx % 6)
      0: return 64'd0;
      1: return 64'd1;
      2: return ones;
      3: return 64'd1 << (w - 1);
      4: return ones >> 1;
      default: return 64'h5A5A_A5A5_3C3C_C3C3 & ones;
    endcase
  endfunction

  function automatic logic [63:0] pack(input int base, input int step, input int w);
    logic [63:0] v = '0;
    for (int k = 0; k < 64 / w; k++) v = v | (pattern(base + step * k, w) << (k * w));
    return v;
  endfunction

  task automatic check64(input string tag, input logic [63:0] got, input logic [63:0] exp);
    testCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
    testCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic string modeTag(input logic [1:0] m);
    case (m)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic runVec(input logic [63:0] a, input logic [63:0] b, input logic [1:0] m,
                        input bit boundary);
    logic [63:0] es;
    logic [7:0]  ec;
    logic [7:0]  used;
    model(a, b, m, es, ec);
    @(negedge clk);
    opA = a; opB = b; laneMode = m;
    @(negedge clk);
    check64(boundary ? "R5" : modeTag(m), sumOut, es);
    used = 8'((16'd1 << (8 >> m)) - 1);
    check8("R6", carryOut & used, ec & used);
    check8("R7", carryOut & ~used, 8'h00);
  endtask

  initial begin
    #(5 * 150000);
    testCount++; failCount++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [63:0] es;
    logic [7:0]  ec;
    repeat (3) @(negedge clk);
    check64("R8 reset sum", sumOut, 64'd0);
    check8("R8 reset carry", carryOut, 8'd0);
    rstN = 1'b1;

    // R5: all-ones lanes plus one, every mode, with neighbour lanes holding data
    for (int m = 0; m < 4; m++) begin
      runVec(64'hFFFF_FFFF_FFFF_FFFF, pack(1, 0, 8 << m), 2'(m), 1'b1);
      runVec(64'hFF00_FF00_FF00_FF00 | pack(2, 2, 8 << m), pack(1, 1, 8 << m), 2'(m), 1'b1);
    end

    // R1..R4 sweep of corner-value pairs, rotated across lanes
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          runVec(pack(i, 1, 8 << m), pack(j, 2, 8 << m), 2'(m), 1'b0);

    // pseudo-random operands, mode switching every cycle
    for (int n = 0; n < 400; n++) begin
      logic [63:0] ra, rb;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 7); rng = rng ^ (rng << 17);
      ra = rng;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 7); rng = rng ^ (rng << 17);
      rb = rng;
      runVec(ra, rb, 2'(n % 4), 1'b0);
    end

    // R8: one-cycle latency, output holds until the next rising edge
    @(negedge clk);
    opA = 64'h0000_0000_0000_00FF; opB = 64'h1; laneMode = 2'b11;
    @(negedge clk);
    opA = 64'h1234; opB = 64'h1; laneMode = 2'b00;
    #1;
    check64("R8 hold", sumOut, 64'h100);
    model(64'h1234, 64'h1, 2'b00, es, ec);
    @(negedge clk);
    check64("R8 next", sumOut, es);

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule